// File: doc/BRIEF.md
# Multi-Channel Interval Timer Array

A memory-mapped target holding a parameterized number of independent 32-bit timers. Each timer owns a free-running cycle counter, a periodic interrupt generator, an interrupt enable and a pending-interrupt latch. Each timer also drives its own interrupt line. A host reaches all timers through a single request/response port. A request carries an address, a write enable, write data and byte enables. The response comes back exactly one cycle later with read data and an error flag.

The timers share one flat address window. Address bits [12:4] pick the timer, so each timer takes 16 bytes. Bits [3:2] pick the register within that timer. The cycle counter never stops and does not depend on the interrupt path. The interrupt path uses a private down-counter that reloads from the period. Any access that falls outside the window, names a timer that does not exist, or is not word-aligned gets an error response. Such an access changes nothing, so the block can also sit on an interconnect as the default target.

Top module: `mtimer_array`

## Requirements
- R1: Every request presented with req_valid_i high is accepted (req_ready_o is high), and exactly one response follows on the next cycle: rsp_valid_o is high one cycle after each accepted request and low otherwise.
- R2: A request whose address bits [31:13] differ from those of BASE_ADDR returns rsp_err_o=1 with rsp_rdata_o=0.
- R3: A request whose timer index (bits [12:4]) is at or above N_TIMERS, or whose bits [1:0] are non-zero, returns rsp_err_o=1 with rsp_rdata_o=0, and its write changes no timer state.
- R4: Offset 0x0 is the cycle counter. It increases by one on every clock. A read returns its value before the accepting edge. A write loads it, so a read accepted on the next cycle returns exactly the written value.
- R5: Offset 0x4 is the interrupt enable. A write sets it when the write data masked by the byte enables is non-zero, and clears it otherwise. A read returns 1 or 0 in bit 0 with the other bits zero.
- R6: Offset 0x8 is the period. A write stores it, and a read returns it. Writing it also clears that timer's enable, so its interrupt line drops on the next cycle.
- R7: If the enable is set at edge E with period P (P>=1), the pending latch sets at edge E+P and again every P cycles after that.
- R8: Offset 0xC is the acknowledge register. Any write to it clears the pending latch. A read returns 1 in bit 0 while an interrupt is pending and 0 otherwise.
- R9: irq_o[i] is the AND of timer i's pending latch and its enable. Clearing the enable lowers the line but leaves the pending latch set.
- R10: A bus write takes priority over internal updates in the same cycle. An acknowledge that coincides with an expiry leaves the pending latch clear.
- R11: Byte enable bit k guards bits [8k+7:8k] of writes to the cycle counter and the period. Bytes that are not enabled keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (always high) |
| req_addr_i | input | 32 | Byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | 32 | Read data, zero on error or write |
| rsp_err_o | output | 1 | Error response |
| irq_o | output | N_TIMERS | Per-timer interrupt line |

## Verification
The assertions assume that every request is accepted in the cycle it is presented. They also assume that request fields are known whenever req_valid_i is high, so the address checks see a defined index and offset. The bench changes inputs only at falling edges and holds each request for exactly one rising edge. Its random addresses are limited to a few classes: valid registers, indices just past N_TIMERS, misaligned offsets, and a single flipped window bit. Every response therefore has an error outcome the bench can predict.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned TMR_W  = 32;
  localparam int unsigned BE_W   = TMR_W / 8;
  localparam int unsigned SLOT_B = 4;   // byte bits per timer slot
  localparam int unsigned IDX_W  = 9;

  typedef enum logic [1:0] {
    REG_TIME   = 2'd0,
    REG_RUN    = 2'd1,
    REG_PERIOD = 2'd2,
    REG_ACK    = 2'd3
  } mt_reg_e;

  function automatic logic [TMR_W-1:0] be_mask(input logic [BE_W-1:0] be);
    logic [TMR_W-1:0] m;
    for (int b = 0; b < BE_W; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [TMR_W-1:0] be_merge(input logic [TMR_W-1:0] old_v,
                                                 input logic [TMR_W-1:0] new_v,
                                                 input logic [BE_W-1:0]  be);
    logic [TMR_W-1:0] m;
    m = be_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int unsigned N_TIMERS  = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic [IDX_W-1:0]  idx_o,
  output mt_reg_e           sel_o
);
  localparam int unsigned WIN_LO = SLOT_B + IDX_W;
  localparam logic [IDX_W:0] N_L = (IDX_W+1)'(N_TIMERS);

  logic in_win, in_rng, aligned;

  assign idx_o   = addr_i[WIN_LO-1:SLOT_B];
  assign sel_o   = mt_reg_e'(addr_i[SLOT_B-1:2]);
  assign in_win  = addr_i[ADDR_W-1:WIN_LO] == BASE_ADDR[ADDR_W-1:WIN_LO];
  assign in_rng  = {1'b0, idx_o} < N_L;
  assign aligned = addr_i[1:0] == 2'b00;
  assign ok_o    = in_win & in_rng & aligned;
endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel
  import mtimer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  mt_reg_e          sel_i,
  input  logic [TMR_W-1:0] wdata_i,
  input  logic [BE_W-1:0]  be_i,
  output logic [TMR_W-1:0] time_o,
  output logic             run_o,
  output logic [TMR_W-1:0] period_o,
  output logic             pend_o,
  output logic             irq_o
);
  logic [TMR_W-1:0] time_q, period_q, cnt_q;
  logic             run_q, pend_q;
  logic             wr_time, wr_run, wr_per, wr_ack, run_set, expire;

  assign wr_time = wr_i & (sel_i == REG_TIME);
  assign wr_run  = wr_i & (sel_i == REG_RUN);
  assign wr_per  = wr_i & (sel_i == REG_PERIOD);
  assign wr_ack  = wr_i & (sel_i == REG_ACK);
  assign run_set = |(wdata_i & be_mask(be_i));
  // bus writes to enable/period override a same-cycle expiry
  assign expire  = run_q & (cnt_q <= TMR_W'(1)) & ~wr_run & ~wr_per;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else if (wr_time) time_q <= be_merge(time_q, wdata_i, be_i);
    else time_q <= time_q + TMR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      period_q <= '0;
    end else if (wr_run) begin
      run_q <= run_set;
    end else if (wr_per) begin
      run_q    <= 1'b0;
      period_q <= be_merge(period_q, wdata_i, be_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_run) begin
      if (run_set) cnt_q <= period_q;
    end else if (run_q && !wr_per) begin
      if (cnt_q <= TMR_W'(1)) cnt_q <= period_q;
      else cnt_q <= cnt_q - TMR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (wr_ack) pend_q <= 1'b0;
    else if (expire) pend_q <= 1'b1;
  end

  assign time_o   = time_q;
  assign run_o    = run_q;
  assign period_o = period_q;
  assign pend_o   = pend_q;
  assign irq_o    = pend_q & run_q;
endmodule

// File: rtl/mtimer_array.sv
module mtimer_array
  import mtimer_pkg::*;
#(
  parameter int unsigned N_TIMERS  = 4,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [31:0]         req_addr_i,
  input  logic                req_we_i,
  input  logic [31:0]         req_wdata_i,
  input  logic [3:0]          req_be_i,
  output logic                rsp_valid_o,
  output logic [31:0]         rsp_rdata_o,
  output logic                rsp_err_o,
  output logic [N_TIMERS-1:0] irq_o
);
  logic             dec_ok;
  logic [IDX_W-1:0] dec_idx;
  mt_reg_e          dec_sel;
  logic             wr_acc;
  logic [TMR_W-1:0] rd_d;

  logic [TMR_W-1:0] time_a   [N_TIMERS];
  logic [TMR_W-1:0] period_a [N_TIMERS];
  logic             run_a    [N_TIMERS];
  logic             pend_a   [N_TIMERS];

  assign req_ready_o = 1'b1;

  mtimer_decode #(
    .N_TIMERS (N_TIMERS),
    .ADDR_W   (32),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i(req_addr_i),
    .ok_o  (dec_ok),
    .idx_o (dec_idx),
    .sel_o (dec_sel)
  );

  assign wr_acc = req_valid_i & req_we_i & dec_ok;

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
    mtimer_channel u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_acc && (dec_idx == IDX_W'(i))),
      .sel_i   (dec_sel),
      .wdata_i (req_wdata_i),
      .be_i    (req_be_i),
      .time_o  (time_a[i]),
      .run_o   (run_a[i]),
      .period_o(period_a[i]),
      .pend_o  (pend_a[i]),
      .irq_o   (irq_o[i])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (dec_idx == IDX_W'(i)) begin
        unique case (dec_sel)
          REG_TIME:   rd_d = time_a[i];
          REG_RUN:    rd_d = {{(TMR_W-1){1'b0}}, run_a[i]};
          REG_PERIOD: rd_d = period_a[i];
          REG_ACK:    rd_d = {{(TMR_W-1){1'b0}}, pend_a[i]};
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & ~dec_ok;
      rsp_rdata_o <= (req_valid_i && !req_we_i && dec_ok) ? rd_d : '0;
    end
  end
endmodule

// File: rtl/mtimer_array_chk.sv
module mtimer_array_chk #(
  parameter int unsigned N_TIMERS  = 4,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [31:0]         req_addr_i,
  input logic                req_we_i,
  input logic [31:0]         req_wdata_i,
  input logic                rsp_valid_o,
  input logic [31:0]         rsp_rdata_o,
  input logic                rsp_err_o,
  input logic [N_TIMERS-1:0] irq_o
);
  logic in_win, aligned;
  assign in_win  = req_addr_i[31:13] == BASE_ADDR[31:13];
  assign aligned = req_addr_i[1:0] == 2'b00;

  p_rsp_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_err_needs_rsp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_err_o);
  p_outside_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !in_win) |=> rsp_err_o);
  p_err_zero_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == 32'd0));
  p_misaligned_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !aligned) |=> rsp_err_o);

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_irq
    logic hit_i;
    assign hit_i = req_valid_i && req_we_i && in_win && aligned &&
                   (req_addr_i[12:4] == 9'(i));
    p_period_disarms_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && req_addr_i[3:2] == 2'd2) |=> !irq_o[i]);
    p_enable_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && req_addr_i[3:2] == 2'd1 && req_wdata_i == 32'd0) |=> !irq_o[i]);
    p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && req_addr_i[3:2] == 2'd3) |=> !irq_o[i]);
  end
endmodule

bind mtimer_array mtimer_array_chk #(
  .N_TIMERS (N_TIMERS),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_we_i   (req_we_i),
  .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o  (rsp_err_o),
  .irq_o      (irq_o)
);

// File: tb/mtimer_array_test.sv
`timescale 1ns/1ps
module mtimer_array_test;
  localparam int unsigned NT   = 4;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NT-1:0] irq;

  int checks = 0, failures = 0, edge_cnt = 0;
  bit done = 1'b0;

  logic [31:0] m_tbase [NT];
  int          m_tcyc  [NT];
  logic [31:0] m_period[NT];
  logic        m_run   [NT];

  always #4 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  mtimer_array #(.N_TIMERS(NT), .BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] addr_of(input int idx, input int off);
    return BASE + 32'(idx * 16 + off);
  endfunction

  function automatic logic [31:0] exp_time(input int idx, input int ec);
    return m_tbase[idx] + 32'(ec - 1 - m_tcyc[idx]);
  endfunction

  // call at a falling edge; returns at the falling edge after the response
  task automatic bus(input logic [31:0] a, input logic w, input logic [31:0] d,
                     input logic [3:0] be, output logic [31:0] rd, output logic e,
                     output int ec);
    req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d; req_be = be;
    @(posedge clk);
    #1 ec = edge_cnt;
    @(negedge clk);
    chk("R1 rsp_valid after request", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata; e = rsp_err;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic e;
    int ec;
    void'($urandom(32'd20070505));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 irq after reset", {28'b0, irq}, 32'd0);
    chk("R1 no response when idle", {31'b0, rsp_valid}, 32'd0);
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    bus(addr_of(0, 8), 0, 0, 4'hF, rd, e, ec);
    chk("R6 period reset", rd, 32'd0);
    bus(addr_of(0, 4), 0, 0, 4'hF, rd, e, ec);
    chk("R5 enable reset", rd, 32'd0);
    @(negedge clk);
    chk("R1 idle after gap", {31'b0, rsp_valid}, 32'd0);

    // initialise the model: load every cycle counter
    for (int i = 0; i < int'(NT); i++) begin
      bus(addr_of(i, 0), 1, 32'h100 * i, 4'hF, rd, e, ec);
      m_tbase[i] = 32'h100 * i; m_tcyc[i] = ec;
      m_period[i] = '0; m_run[i] = 1'b0;
    end
    // R4 write then immediate read returns the written value
    bus(addr_of(3, 0), 1, 32'hFFFF_FFFE, 4'hF, rd, e, ec);
    m_tbase[3] = 32'hFFFF_FFFE; m_tcyc[3] = ec;
    bus(addr_of(3, 0), 0, 0, 4'hF, rd, e, ec);
    chk("R4 read after write", rd, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    bus(addr_of(3, 0), 0, 0, 4'hF, rd, e, ec);
    chk("R4 counter wraps", rd, exp_time(3, ec));

    // constrained random accesses
    for (int it = 0; it < 600; it++) begin
      int idx, off, k;
      logic bad, w, exp_err;
      logic [31:0] d, a, old;
      logic [3:0] be;
      idx = int'($urandom % (NT + 2));
      k = int'($urandom % 5);
      off = (k < 4) ? k * 4 : int'($urandom % 4) * 4 + 1 + int'($urandom % 3);
      bad = ($urandom % 8) == 0;
      w = $urandom % 2;
      d = $urandom;
      be = 4'($urandom);
      a = addr_of(idx, off) ^ (bad ? 32'h0010_0000 : 32'h0);
      exp_err = bad || (idx >= int'(NT)) || (off % 4 != 0);
      bus(a, w, d, be, rd, e, ec);
      chk(bad ? "R2 window error" : "R3 index/alignment error", {31'b0, e}, {31'b0, exp_err});
      if (exp_err) chk("R2 error data zero", rd, 32'd0);
      else if (!w) begin
        case (off)
          0:  chk("R4 cycle counter read", rd, exp_time(idx, ec));
          4:  chk("R5 enable read", rd, {31'b0, m_run[idx]});
          8:  chk("R6 period read", rd, m_period[idx]);
          default: ;
        endcase
      end else begin
        case (off)
          0: begin
            old = exp_time(idx, ec);
            m_tbase[idx] = (old & ~mask_of(be)) | (d & mask_of(be));
            m_tcyc[idx] = ec;
          end
          4: m_run[idx] = |(d & mask_of(be));
          8: begin
            m_period[idx] = (m_period[idx] & ~mask_of(be)) | (d & mask_of(be));
            m_run[idx] = 1'b0;
          end
          default: ;
        endcase
      end
      if (($urandom % 4) == 0) @(negedge clk);
    end

    // R7/R8/R9 interrupt cadence on timer 1
    bus(addr_of(1, 8), 1, 32'd5, 4'hF, rd, e, ec);
    bus(addr_of(1, 12), 1, 32'd0, 4'hF, rd, e, ec);
    bus(addr_of(1, 4), 1, 32'd1, 4'hF, rd, e, ec);
    for (int kk = 1; kk <= 5; kk++) begin
      @(negedge clk);
      chk("R7 irq after period", {31'b0, irq[1]}, {31'b0, kk == 5});
    end
    bus(addr_of(1, 12), 0, 0, 4'hF, rd, e, ec);
    chk("R8 pending read", rd, 32'd1);
    bus(addr_of(1, 12), 1, 32'd0, 4'hF, rd, e, ec);
    chk("R8 ack clears irq", {31'b0, irq[1]}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 periodic re-fire", {31'b0, irq[1]}, 32'd1);
    bus(addr_of(1, 4), 1, 32'd0, 4'hF, rd, e, ec);
    chk("R9 irq off with enable clear", {31'b0, irq[1]}, 32'd0);
    bus(addr_of(1, 12), 0, 0, 4'hF, rd, e, ec);
    chk("R9 pending kept", rd, 32'd1);
    bus(addr_of(1, 4), 1, 32'h0100, 4'h2, rd, e, ec);
    chk("R9 irq back with enable", {31'b0, irq[1]}, 32'd1);
    bus(addr_of(1, 8), 1, 32'd7, 4'hF, rd, e, ec);
    chk("R6 period write disarms", {31'b0, irq[1]}, 32'd0);
    bus(addr_of(1, 4), 0, 0, 4'hF, rd, e, ec);
    chk("R6 enable cleared by period", rd, 32'd0);
    bus(addr_of(1, 8), 0, 0, 4'hF, rd, e, ec);
    chk("R6 period stored", rd, 32'd7);
    bus(addr_of(1, 4), 1, 32'h0100, 4'h1, rd, e, ec);
    bus(addr_of(1, 4), 0, 0, 4'hF, rd, e, ec);
    chk("R5 masked-out data clears", rd, 32'd0);

    // R10 acknowledge coinciding with expiry
    bus(addr_of(1, 8), 1, 32'd3, 4'hF, rd, e, ec);
    bus(addr_of(1, 12), 1, 32'd0, 4'hF, rd, e, ec);
    bus(addr_of(1, 4), 1, 32'd9, 4'hF, rd, e, ec);
    repeat (2) @(negedge clk);
    bus(addr_of(1, 12), 1, 32'd0, 4'hF, rd, e, ec);
    chk("R10 ack wins over expiry", {31'b0, irq[1]}, 32'd0);
    bus(addr_of(1, 12), 0, 0, 4'hF, rd, e, ec);
    chk("R10 pending stays clear", rd, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7 next expiry after ack", {31'b0, irq[1]}, 32'd1);

    // R11 byte enables, R3 no state change on error
    bus(addr_of(2, 8), 1, 32'h1122_3344, 4'hF, rd, e, ec);
    bus(addr_of(2, 8), 1, 32'hAABB_CCDD, 4'b0101, rd, e, ec);
    bus(addr_of(2, 8), 0, 0, 4'hF, rd, e, ec);
    chk("R11 partial period write", rd, 32'h11BB_33DD);
    bus(addr_of(2, 8) + 32'd1, 1, 32'hFFFF_FFFF, 4'hF, rd, e, ec);
    chk("R3 misaligned write error", {31'b0, e}, 32'd1);
    bus(addr_of(2, 8), 0, 0, 4'hF, rd, e, ec);
    chk("R3 misaligned write ignored", rd, 32'h11BB_33DD);
    bus(addr_of(NT, 8), 0, 0, 4'hF, rd, e, ec);
    chk("R3 index at limit errors", {31'b0, e}, 32'd1);
    bus(addr_of(0, 0) ^ 32'h8000_0000, 0, 0, 4'hF, rd, e, ec);
    chk("R2 outside window errors", {31'b0, e}, 32'd1);
    chk("R2 outside window data", rd, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule